// File: doc/BRIEF.md
# Slotted-Stream Event Fragment Builder

This block takes the parallel word stream recovered from a time-multiplexed link and sorts it into per-channel storage. The stream is organised in frames. Each frame opens with a separator word, and 18 slot words follow it. A word's position after the separator names its source channel. The block does not decode any field in a word to find where it goes. The slot position alone selects the destination.

The memory is split into one region per channel, each `PART_DEPTH` words deep. A non-zero slot word is appended to its channel's region, so that channel's fragment for an event (a header, some hits and a trailer) builds up in contiguous locations. Separator words and all-zero slot words are examined but never stored. The block watches the separator position. If a non-zero word arrives where a separator belongs, the block declares loss of sync and drops input until a clean separator arrives.

A downstream stage drains one region at a time through a read port. The read port returns the region's words in arrival order. The read that hands out the last stored word frees the region.

Top module: `slot_frag_builder`

## Requirements
- R1: After reset, every partition count, write pointer and overflow flag is zero, `sync_lost` is 0 and `rd_valid` is 0.
- R2: A zero word at the separator position is skipped and not stored. The separator position is the first word after reset, the word after the 18th slot, or any word with `in_frame_start` high. The next word is then slot 0.
- R3: The n-th word after a separator (n = 0..17) belongs to channel n. If the word is non-zero, it is written at that partition's write pointer, and the count of that partition rises by 1.
- R4: An all-zero slot word is not stored, but it still advances the slot position.
- R5: A zero word with `in_frame_start` high in the middle of a frame restarts slot counting, so the following word is slot 0.
- R6: A non-zero word at the separator position raises `sync_lost` from the next cycle on. While `sync_lost` is high, every word is dropped until a zero word with `in_frame_start` high arrives. That word clears `sync_lost` and is treated as a separator.
- R7: A non-zero word for a partition that already holds `PART_DEPTH` words is discarded. The count of that partition stays unchanged, and its overflow flag is set and stays set.
- R8: `rd_en` with `rd_sel` = c returns the oldest not-yet-read word of partition c on `rd_data`, with `rd_valid` high, one cycle later. If every stored word of c has already been read, `rd_valid` stays low.
- R9: The read that returns the last stored word of a partition raises `rd_last`. One cycle later, that partition's count, write pointer and overflow flag are zero.
- R10: While `in_valid` is low, `in_word` and `in_frame_start` have no effect.
- R11: A partition's write pointer is its count modulo `PART_DEPTH`, so it wraps to 0 when the partition is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | WORD_W | Recovered link word |
| in_valid | input | 1 | `in_word` carries a word this cycle |
| in_frame_start | input | 1 | This word is a frame-opening separator |
| rd_en | input | 1 | Read one word from the selected partition |
| rd_sel | input | CHW | Partition to read |
| rd_data | output | WORD_W | Word read, valid with `rd_valid` |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_last | output | 1 | This word emptied its partition |
| part_wr_ptr | output | NUM_CH*AW | Write pointer per partition, channel c at bits [c*AW +: AW] |
| part_count | output | NUM_CH*CW | Stored word count per partition, channel c at bits [c*CW +: CW] |
| part_ovf | output | NUM_CH | Overflow flag per partition |
| sync_lost | output | 1 | Frame alignment lost, input dropped |

## Verification
The overflow path is the case hardest to reach from the ports. It needs one channel to fill its whole region while the slot framing stays intact, and in the default setup that means eight complete frames into the same slot, followed by a ninth frame. The bench sends a run of frames where only channel 5 carries data. It checks that the count saturates and the pointer wraps, then that the next word is dropped with the flag set, and finally it drains the region to see the flag clear. Loss of sync is reached by placing a non-zero word where the separator belongs. The bench then shows that a full frame of junk is dropped, and that alignment comes back only on a zero word with the frame marker.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    TRK_SEP  = 2'd0,
    TRK_SLOT = 2'd1,
    TRK_HUNT = 2'd2
  } trk_state_e;

  // flat address of entry idx in partition ch
  function automatic int unsigned part_addr(input int unsigned ch,
                                            input int unsigned idx,
                                            input int unsigned depth);
    return ch * depth + idx;
  endfunction

  // increment with wrap at lim
  function automatic int unsigned step_wrap(input int unsigned v,
                                            input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // write pointer implied by a fill count
  function automatic int unsigned ptr_of_count(input int unsigned cnt,
                                               input int unsigned depth);
    return cnt % depth;
  endfunction

endpackage

// File: rtl/sfb_slot_tracker.sv
module sfb_slot_tracker
  import sfb_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int WORD_W = 32,
  parameter int CHW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              in_frame_start,
  output logic              wr_req,
  output logic [CHW-1:0]    wr_ch,
  output logic              sync_lost,
  output logic              sep_evt,
  output logic              empty_evt,
  output logic              sync_err_evt
);

  localparam logic [CHW-1:0] LAST_SLOT = CHW'(NUM_CH - 1);

  trk_state_e     state_q, state_d;
  logic [CHW-1:0] slot_q, slot_d;
  logic           word_zero;
  logic           sep_pos;

  assign word_zero = (in_word == '0);
  assign sep_pos   = (state_q == TRK_SEP) || in_frame_start;

  always_comb begin
    state_d      = state_q;
    slot_d       = slot_q;
    wr_req       = 1'b0;
    sep_evt      = 1'b0;
    empty_evt    = 1'b0;
    sync_err_evt = 1'b0;
    if (in_valid) begin
      if (state_q == TRK_HUNT) begin
        if (in_frame_start && word_zero) begin
          sep_evt = 1'b1;
          state_d = TRK_SLOT;
          slot_d  = '0;
        end
      end else if (sep_pos) begin
        if (word_zero) begin
          sep_evt = 1'b1;
          state_d = TRK_SLOT;
          slot_d  = '0;
        end else begin
          sync_err_evt = 1'b1;
          state_d      = TRK_HUNT;
        end
      end else begin
        if (word_zero) empty_evt = 1'b1;
        else           wr_req    = 1'b1;
        if (slot_q == LAST_SLOT) state_d = TRK_SEP;
        else slot_d = CHW'(step_wrap(int'(slot_q), NUM_CH));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TRK_SEP;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign wr_ch     = slot_q;
  assign sync_lost = (state_q == TRK_HUNT);

  // R6
  sync_err_to_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_evt |=> sync_lost);

  // R2
  sep_restarts_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sep_evt |=> (slot_q == '0) && !sync_lost);

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_q) < NUM_CH);

endmodule

// File: rtl/sfb_part_ctrl.sv
module sfb_part_ctrl
  import sfb_pkg::*;
#(
  parameter int NUM_CH = 18,
  parameter int DEPTH  = 8,
  parameter int CHW    = 5,
  parameter int AW     = 3,
  parameter int CW     = 4,
  parameter int MAW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [CHW-1:0]       wr_ch,
  input  logic                 rd_en,
  input  logic [CHW-1:0]       rd_sel,
  output logic                 mem_we,
  output logic [MAW-1:0]       mem_waddr,
  output logic [MAW-1:0]       mem_raddr,
  output logic                 rd_fire,
  output logic                 rd_done,
  output logic [NUM_CH*AW-1:0] part_wr_ptr,
  output logic [NUM_CH*CW-1:0] part_count,
  output logic [NUM_CH-1:0]    part_ovf
);

  logic [CW-1:0]  cnt_v [NUM_CH];
  logic [AW-1:0]  wp_v  [NUM_CH];
  logic [AW-1:0]  rp_v  [NUM_CH];

  logic [CHW-1:0] rsel_i;
  logic           wr_full;
  logic           ovf_set;
  logic [AW-1:0]  wr_idx;
  logic [CW-1:0]  rsel_cnt;
  logic [AW-1:0]  rsel_ptr;

  assign rsel_i   = (int'(rd_sel) < NUM_CH) ? rd_sel : '0;
  assign rsel_cnt = cnt_v[rsel_i];
  assign rsel_ptr = rp_v[rsel_i];

  assign wr_full  = (cnt_v[wr_ch] == CW'(DEPTH));
  assign mem_we   = wr_req && !wr_full;
  assign ovf_set  = wr_req && wr_full;

  assign rd_fire  = rd_en && (int'(rd_sel) < NUM_CH) && (CW'(rsel_ptr) < rsel_cnt);
  assign rd_done  = rd_fire && (CW'(rsel_ptr) + CW'(1) == rsel_cnt);

  // a drain finishing this cycle on the written partition frees entry 0
  assign wr_idx    = (rd_done && (rsel_i == wr_ch)) ? '0 : wp_v[wr_ch];
  assign mem_waddr = MAW'(part_addr(int'(wr_ch), int'(wr_idx), DEPTH));
  assign mem_raddr = MAW'(part_addr(int'(rsel_i), int'(rsel_ptr), DEPTH));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_part
    logic [CW-1:0] cnt_r;
    logic [AW-1:0] wp_r;
    logic [AW-1:0] rp_r;
    logic          ovf_r;
    logic          w_c, o_c, r_c, d_c;

    assign w_c = mem_we  && (wr_ch  == CHW'(c));
    assign o_c = ovf_set && (wr_ch  == CHW'(c));
    assign r_c = rd_fire && (rsel_i == CHW'(c));
    assign d_c = rd_done && (rsel_i == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_r <= '0;
        wp_r  <= '0;
        rp_r  <= '0;
        ovf_r <= 1'b0;
      end else begin
        if (d_c) begin
          cnt_r <= w_c ? CW'(1) : '0;
          wp_r  <= w_c ? AW'(step_wrap(0, DEPTH)) : '0;
          rp_r  <= '0;
        end else begin
          if (w_c) begin
            cnt_r <= cnt_r + CW'(1);
            wp_r  <= AW'(step_wrap(int'(wp_r), DEPTH));
          end
          if (r_c) rp_r <= rp_r + AW'(1);
        end
        ovf_r <= (ovf_r && !d_c) || o_c;
      end
    end

    assign cnt_v[c] = cnt_r;
    assign wp_v[c]  = wp_r;
    assign rp_v[c]  = rp_r;
    assign part_count[c*CW +: CW]  = cnt_r;
    assign part_wr_ptr[c*AW +: AW] = wp_r;
    assign part_ovf[c]             = ovf_r;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_r) <= DEPTH);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_r && !d_c) |=> ovf_r);

    // R11
    ptr_tracks_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wp_r) == int'(ptr_of_count(int'(cnt_r), DEPTH)));

    // R9
    drain_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_c |=> (cnt_r <= CW'(1)) && (rp_r == '0));
  end

endmodule

// File: rtl/sfb_part_mem.sv
module sfb_part_mem #(
  parameter int WORD_W  = 32,
  parameter int ENTRIES = 144,
  parameter int MAW     = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MAW-1:0]    waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [MAW-1:0]    raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] store [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/slot_frag_builder.sv
module slot_frag_builder #(
  parameter  int NUM_CH     = 18,
  parameter  int WORD_W     = 32,
  parameter  int PART_DEPTH = 8,
  localparam int CHW        = $clog2(NUM_CH),
  localparam int AW         = $clog2(PART_DEPTH),
  localparam int CW         = $clog2(PART_DEPTH + 1),
  localparam int ENTRIES    = NUM_CH * PART_DEPTH,
  localparam int MAW        = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    in_word,
  input  logic                 in_valid,
  input  logic                 in_frame_start,
  input  logic                 rd_en,
  input  logic [CHW-1:0]       rd_sel,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic                 rd_last,
  output logic [NUM_CH*AW-1:0] part_wr_ptr,
  output logic [NUM_CH*CW-1:0] part_count,
  output logic [NUM_CH-1:0]    part_ovf,
  output logic                 sync_lost
);

  logic           wr_req;
  logic [CHW-1:0] wr_ch;
  logic           sep_evt, empty_evt, sync_err_evt;
  logic           mem_we;
  logic [MAW-1:0] mem_waddr, mem_raddr;
  logic           rd_fire, rd_done;

  sfb_slot_tracker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CHW(CHW)) u_trk (
    .clk, .rst_n, .in_word, .in_valid, .in_frame_start,
    .wr_req, .wr_ch, .sync_lost, .sep_evt, .empty_evt, .sync_err_evt
  );

  sfb_part_ctrl #(.NUM_CH(NUM_CH), .DEPTH(PART_DEPTH), .CHW(CHW),
                  .AW(AW), .CW(CW), .MAW(MAW)) u_ctrl (
    .clk, .rst_n, .wr_req, .wr_ch, .rd_en, .rd_sel,
    .mem_we, .mem_waddr, .mem_raddr, .rd_fire, .rd_done,
    .part_wr_ptr, .part_count, .part_ovf
  );

  sfb_part_mem #(.WORD_W(WORD_W), .ENTRIES(ENTRIES), .MAW(MAW)) u_mem (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(in_word),
    .re(rd_fire), .raddr(mem_raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      rd_last  <= rd_done;
    end
  end

  // R2
  sep_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sep_evt |-> !mem_we);

  // R4
  empty_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> !mem_we);

  // R6
  hunt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> !mem_we);

  // R9
  last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

endmodule

// File: tb/slot_frag_builder_tb_top.sv
module slot_frag_builder_tb_top;

  localparam int NCH = 18;
  localparam int W   = 32;
  localparam int DEP = 8;
  localparam int CHW = $clog2(NCH);
  localparam int AW  = $clog2(DEP);
  localparam int CW  = $clog2(DEP + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [W-1:0]      in_word = '0;
  logic              in_valid = 1'b0;
  logic              in_frame_start = 1'b0;
  logic              rd_en = 1'b0;
  logic [CHW-1:0]    rd_sel = '0;
  logic [W-1:0]      rd_data;
  logic              rd_valid;
  logic              rd_last;
  logic [NCH*AW-1:0] part_wr_ptr;
  logic [NCH*CW-1:0] part_count;
  logic [NCH-1:0]    part_ovf;
  logic              sync_lost;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] slot_w [NCH];
  int cnt_before [NCH];

  always #5 clk = ~clk;

  slot_frag_builder #(.NUM_CH(NCH), .WORD_W(W), .PART_DEPTH(DEP)) dut_i (
    .clk, .rst_n, .in_word, .in_valid, .in_frame_start, .rd_en, .rd_sel,
    .rd_data, .rd_valid, .rd_last, .part_wr_ptr, .part_count, .part_ovf,
    .sync_lost
  );

  function automatic int cnt_of(input int c);
    return int'(part_count[c*CW +: CW]);
  endfunction

  function automatic int ptr_of(input int c);
    return int'(part_wr_ptr[c*AW +: AW]);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input logic fs);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_frame_start = fs;
    @(negedge clk);
    in_valid = 1'b0; in_frame_start = 1'b0; in_word = '0;
  endtask

  task automatic send_frame();
    send_word('0, 1'b1);
    for (int i = 0; i < NCH; i++) send_word(slot_w[i], 1'b0);
  endtask

  task automatic read_one(input int c);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = CHW'(c);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic snap_counts();
    for (int c = 0; c < NCH; c++) cnt_before[c] = cnt_of(c);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) begin
      check("R1 count", W'(cnt_of(c)), 0);
      check("R1 ptr",   W'(ptr_of(c)), 0);
    end
    check("R1 ovf", W'(part_ovf), 0);
    check("R1 sync_lost", W'(sync_lost), 0);
    check("R1 rd_valid", W'(rd_valid), 0);
  endtask

  task automatic t_basic_frame();
    for (int i = 0; i < NCH; i++) slot_w[i] = (i % 2 == 0) ? (32'hA000_0000 | W'(i)) : '0;
    send_frame();
    for (int c = 0; c < NCH; c++) begin
      if (c % 2 == 0) check("R3 slot count", W'(cnt_of(c)), 1);
      else            check("R4 empty slot count", W'(cnt_of(c)), 0);
    end
    check("R2 separator not stored ch0", W'(cnt_of(0)), 1);
  endtask

  task automatic t_drain_single();
    read_one(4);
    check("R8 rd_valid", W'(rd_valid), 1);
    check("R8 rd_data", rd_data, 32'hA000_0004);
    check("R9 rd_last", W'(rd_last), 1);
    check("R9 count cleared", W'(cnt_of(4)), 0);
    read_one(4);
    check("R8 empty read no valid", W'(rd_valid), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < NCH; i++) slot_w[i] = '0;
    slot_w[2] = 32'hB000_0002; send_frame();
    slot_w[2] = 32'hC000_0002; send_frame();
    check("R11 ptr ch2", W'(ptr_of(2)), 3);
    check("R3 count ch2", W'(cnt_of(2)), 3);
    read_one(2);
    check("R8 order 1", rd_data, 32'hA000_0002);
    check("R9 not last 1", W'(rd_last), 0);
    read_one(2);
    check("R8 order 2", rd_data, 32'hB000_0002);
    read_one(2);
    check("R8 order 3", rd_data, 32'hC000_0002);
    check("R9 last 3", W'(rd_last), 1);
    check("R9 ptr ch2 cleared", W'(ptr_of(2)), 0);
  endtask

  task automatic t_restart();
    snap_counts();
    send_word('0, 1'b1);
    for (int i = 0; i < 5; i++) send_word(32'hD000_0000 | W'(i), 1'b0);
    send_word('0, 1'b1);
    send_word(32'hE000_0000, 1'b0);
    for (int i = 1; i < NCH; i++) send_word('0, 1'b0);
    check("R5 ch0 two words", W'(cnt_of(0)), W'(cnt_before[0] + 2));
    check("R5 ch4 one word", W'(cnt_of(4)), W'(cnt_before[4] + 1));
    check("R5 ch5 untouched", W'(cnt_of(5)), W'(cnt_before[5]));
    read_one(0);
    check("R8 ch0 first", rd_data, 32'hA000_0000);
    read_one(0);
    check("R5 ch0 pre-restart", rd_data, 32'hD000_0000);
    read_one(0);
    check("R5 ch0 post-restart", rd_data, 32'hE000_0000);
    check("R9 ch0 last", W'(rd_last), 1);
  endtask

  task automatic t_sync_loss();
    send_word(32'h0000_0055, 1'b1);
    check("R6 sync_lost raised", W'(sync_lost), 1);
    snap_counts();
    for (int i = 0; i < NCH; i++) send_word(32'h1111_0000 | W'(i), 1'b0);
    send_word('0, 1'b0);
    send_word(32'h2222_2222, 1'b1);
    check("R6 still lost", W'(sync_lost), 1);
    for (int c = 0; c < NCH; c++) check("R6 dropped", W'(cnt_of(c)), W'(cnt_before[c]));
    send_word('0, 1'b1);
    check("R6 sync regained", W'(sync_lost), 0);
    send_word(32'h0000_0077, 1'b0);
    check("R6 resumes at ch0", W'(cnt_of(0)), W'(cnt_before[0] + 1));
    for (int i = 1; i < NCH; i++) send_word('0, 1'b0);
    read_one(0);
    check("R6 resumed data", rd_data, 32'h0000_0077);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < NCH; i++) slot_w[i] = '0;
    for (int f = 0; f < DEP; f++) begin
      slot_w[5] = 32'h0000_0500 + W'(f);
      send_frame();
    end
    check("R7 full count", W'(cnt_of(5)), W'(DEP));
    check("R11 ptr wraps", W'(ptr_of(5)), 0);
    check("R7 no ovf yet", W'(part_ovf[5]), 0);
    slot_w[5] = 32'h0000_05FF;
    send_frame();
    check("R7 count held", W'(cnt_of(5)), W'(DEP));
    check("R7 ovf set", W'(part_ovf[5]), 1);
    check("R7 other ovf clear", W'(part_ovf[4]), 0);
    for (int k = 0; k < DEP; k++) begin
      read_one(5);
      check("R8 overflow drain data", rd_data, 32'h0000_0500 + W'(k));
      check("R9 last flag", W'(rd_last), (k == DEP - 1) ? 1 : 0);
    end
    check("R9 ovf cleared", W'(part_ovf[5]), 0);
    check("R9 count cleared", W'(cnt_of(5)), 0);
  endtask

  task automatic t_idle();
    snap_counts();
    send_word('0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_word = 32'hFFFF_FFFF; in_frame_start = 1'b1;
    @(negedge clk);
    in_word = '0; in_frame_start = 1'b0;
    check("R10 idle junk ignored", W'(sync_lost), 0);
    send_word(32'h0000_0088, 1'b0);
    check("R10 slot0 after idle", W'(cnt_of(0)), W'(cnt_before[0] + 1));
    check("R10 ch1 untouched", W'(cnt_of(1)), W'(cnt_before[1]));
    for (int i = 1; i < NCH; i++) send_word('0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_frame();
    t_drain_single();
    t_order();
    t_restart();
    t_sync_loss();
    t_overflow();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule